// File: doc/BRIEF.md
# Latch-and-Clear Performance Counter Bank

This block keeps a bank of saturating event counters for the traffic statistics of a framing data path. One counter tracks good cells or packets handed to the system side in each direction. The others track error and correction events: corrected single-bit header check errors, header-errored cells that were discarded, invalid HDLC flag sequences, short HDLC packets, corrected and uncorrectable SDL headers, packets that fail their CRC check, and PPP header mismatches. Each event source raises its own input bit for one clock per event. The detectors that produce these strobes sit outside this block.

Every counter keeps a live count and a held copy. A single snapshot strobe moves every live count into its held register and starts a new interval in the same clock. An event that arrives in that same clock is not lost; it becomes the first count of the new interval. Software reads only the held copies, through a plain address and data port with no side effects. It is expected to raise the strobe at least once per second, and the width is sized for that rate.

Top module: `pmc_counter_bank`

## Requirements
- R1: The bank has ten counters of parameter width `CNT_W` (default 28). The event bit and read address of each counter is: 0 good transmit, 1 good receive, 2 corrected header single-bit error, 3 HDLC invalid sequence, 4 SDL corrected header, 5 uncorrectable header (discarded cell), 6 HDLC short packet, 7 SDL errored header, 8 bad CRC, 9 PPP header mismatch.
- R2: Outside a snapshot clock, a high event bit adds exactly one to that counter's live count. A low event bit leaves the live count unchanged.
- R3: A live count that has reached all ones stays at all ones on further events and never wraps.
- R4: A clock with `snap_i` high loads every held register with the live count from before that clock and clears the live counts.
- R5: An event in the same clock as `snap_i` is left out of the held value and becomes the count 1 of the new interval.
- R6: Held registers change only in a snapshot clock. Events and reads between strobes leave them unchanged.
- R7: `rd_data_o` shows, without a clock delay, the held value of the counter selected by `rd_addr_i`. Addresses 10 to 15 read as zero.
- R8: While `rst_n` is low at a rising clock edge, all live and held registers clear to zero.
- R9: The counters are independent. An event on one bit changes no other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 10 | One event strobe per counter; bit index as in R1 |
| snap_i | input | 1 | Snapshot-and-clear strobe |
| rd_addr_i | input | 4 | Index of the held register to read |
| rd_data_o | output | CNT_W | Held value of the selected counter |

## Verification
The bound checker checks several rules on every clock, for every counter: the live step of plus one or zero, saturation holding at all ones, the snapshot loading the held register with the old live value, the restart value after a strobe (including a coincident event), the stability of held values between strobes, and the read port's selection and zero result out of range. The bench's scenarios are needed for the rest. These are the mapping of event bits to addresses, the reset clearing values that are only visible after a later snapshot, and long bursts that drive a reduced-width counter into saturation. They also include the end-to-end agreement of read data with an independent behavioural model over random traffic.

// File: rtl/pmc_pkg.sv
// Package pmc_pkg
// Shared constants and the event index map for the performance counter bank.
// Assumes the bank is always indexed through pmc_evt_e.
package pmc_pkg;
    localparam int PMC_NUM_CNT   = 10;
    localparam int PMC_CNT_W_DEF = 28;

    typedef enum logic [3:0] {
        EV_TX_GOOD      = 4'd0,
        EV_RX_GOOD      = 4'd1,
        EV_HDR_FIXED    = 4'd2,
        EV_HDLC_BADSEQ  = 4'd3,
        EV_SDL_FIXED    = 4'd4,
        EV_HDR_DROP     = 4'd5,
        EV_HDLC_SHORT   = 4'd6,
        EV_SDL_BAD      = 4'd7,
        EV_CRC_BAD      = 4'd8,
        EV_PPP_MISMATCH = 4'd9
    } pmc_evt_e;
endpackage

// File: rtl/pmc_sat_counter.sv
// Module pmc_sat_counter
// One saturating live counter with a held copy.
// A snapshot copies live into held and restarts live at the value of the
// coincident event (0 or 1).
// Assumes at most one event per clock and a synchronous active-low reset.
module pmc_sat_counter #(
    parameter int CW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          snap_i,
    output logic [CW-1:0] live_o,
    output logic [CW-1:0] held_o
);
    localparam logic [CW-1:0] MAX_VAL = {CW{1'b1}};

    logic [CW-1:0] live_q;
    logic [CW-1:0] held_q;
    logic          at_max;

    // Flag the saturation point so that an increment is suppressed there
    always_comb at_max = (live_q == MAX_VAL);

    // Live count: restart on snapshot, otherwise saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= '0;
        else if (snap_i)
            live_q <= {{(CW-1){1'b0}}, inc_i};
        else if (inc_i && !at_max)
            live_q <= live_q + 1'b1;
    end

    // Held copy: loaded only by the snapshot strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (snap_i)
            held_q <= live_q;
    end

    assign live_o = live_q;
    assign held_o = held_q;
endmodule

// File: rtl/pmc_read_mux.sv
// Module pmc_read_mux
// Combinational selection of one held value by address.
// Addresses at or beyond NUM return zero. Reading has no side effects.
module pmc_read_mux #(
    parameter int NUM = 10,
    parameter int CW  = 28,
    parameter int AW  = 4
) (
    input  logic [NUM-1:0][CW-1:0] held_i,
    input  logic [AW-1:0]          addr_i,
    output logic [CW-1:0]          data_o
);
    // Pick the addressed held register, zero when out of range
    always_comb begin
        data_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (addr_i == AW'(i))
                data_o = held_i[i];
        end
    end
endmodule

// File: rtl/pmc_counter_bank.sv
// Module pmc_counter_bank
// A bank of NUM_CNT saturating event counters with a shared snapshot-and-clear
// strobe and a read port onto the held values.
// Assumes each event bit is a one-clock strobe per event and that software
// strobes often enough that a live count does not saturate in normal use.
module pmc_counter_bank #(
    parameter int CNT_W   = pmc_pkg::PMC_CNT_W_DEF,
    parameter int NUM_CNT = pmc_pkg::PMC_NUM_CNT,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_i,
    input  logic               snap_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [CNT_W-1:0]   rd_data_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] live_w;
    logic [NUM_CNT-1:0][CNT_W-1:0] held_w;

    // One counter slice per event source
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmc_sat_counter #(.CW(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (evt_i[g]),
            .snap_i (snap_i),
            .live_o (live_w[g]),
            .held_o (held_w[g])
        );
    end

    // Read port onto the held registers
    pmc_read_mux #(.NUM(NUM_CNT), .CW(CNT_W), .AW(ADDR_W)) u_rd (
        .held_i (held_w),
        .addr_i (rd_addr_i),
        .data_o (rd_data_o)
    );
endmodule

// File: rtl/pmc_counter_bank_chk.sv
// Module pmc_counter_bank_chk
// Assertion checker bound to pmc_counter_bank; observes ports and the
// live/held arrays driven by the counter slices.
module pmc_counter_bank_chk #(
    parameter int CNT_W   = 28,
    parameter int NUM_CNT = 10,
    parameter int ADDR_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CNT-1:0]            evt_i,
    input logic                          snap_i,
    input logic [ADDR_W-1:0]             rd_addr_i,
    input logic [CNT_W-1:0]              rd_data_o,
    input logic [NUM_CNT-1:0][CNT_W-1:0] live_w,
    input logic [NUM_CNT-1:0][CNT_W-1:0] held_w
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        // R2: plus one or zero per clock below saturation
        p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!snap_i && live_w[g] != MAXV) |=>
            live_w[g] == $past(live_w[g]) + CNT_W'($past(evt_i[g])));
        // R3: saturation holds
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!snap_i && live_w[g] == MAXV) |=> live_w[g] == MAXV);
        // R4: snapshot loads held with the old live count
        p_snap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            snap_i |=> held_w[g] == $past(live_w[g]));
        // R5: new interval starts at the coincident event
        p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
            snap_i |=> live_w[g] == CNT_W'($past(evt_i[g])));
        // R6: held stable between strobes
        p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !snap_i |=> $stable(held_w[g]));
        // R7: read port returns the selected held value
        p_read_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr_i == ADDR_W'(g)) |-> rd_data_o == held_w[g]);
    end

    // R7: out-of-range addresses read zero
    p_read_oor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr_i) >= NUM_CNT) |-> rd_data_o == '0);
endmodule

bind pmc_counter_bank pmc_counter_bank_chk #(
    .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .snap_i(snap_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .live_w(live_w), .held_w(held_w)
);

// File: tb/tb_pmc_counter_bank.sv
module tb_pmc_counter_bank;
    localparam int CW   = 8;
    localparam int NUM  = 10;
    localparam int AW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NUM-1:0] evt = '0;
    logic           snap = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [CW-1:0]  rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R8";
    int m_live [NUM];
    int m_held [NUM];

    always #4 clk = ~clk;   // 125 MHz

    pmc_counter_bank #(.CNT_W(CW), .NUM_CNT(NUM), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .snap_i(snap),
        .rd_addr_i(addr), .rd_data_o(rdata)
    );

    function automatic int expect_rd(input int a);
        return (a < NUM) ? m_held[a] : 0;
    endfunction

    // One clock: check the read port, drive inputs, update the model at the edge
    task automatic step(input logic [NUM-1:0] e, input logic s, input int a, input logic r);
        @(negedge clk);
        checks++;
        if (int'(rdata) != expect_rd(int'(addr))) begin
            errors++;
            $display("FAIL %s addr %0d actual %0d expected %0d", tag, addr, rdata, expect_rd(int'(addr)));
        end
        evt = e; snap = s; addr = AW'(a); rst_n = r;
        @(posedge clk);
        if (!r) begin
            foreach (m_live[i]) begin m_live[i] = 0; m_held[i] = 0; end
        end else if (s) begin
            foreach (m_live[i]) begin m_held[i] = m_live[i]; m_live[i] = int'(e[i]); end
        end else begin
            foreach (m_live[i]) if (e[i] && m_live[i] < MAXV) m_live[i]++;
        end
    endtask

    task automatic sweep_reads(input int n);
        for (int k = 0; k < n; k++) step('0, 1'b0, k % 16, 1'b1);
    endtask

    initial begin
        foreach (m_live[i]) begin m_live[i] = 0; m_held[i] = 0; end
        // R8: reset state, all addresses read zero
        tag = "R8";
        for (int k = 0; k < 4; k++) step('0, 1'b0, k, 1'b0);
        sweep_reads(16);
        // R1: each event bit lands at its own address (k+1 events on bit k)
        tag = "R1";
        for (int b = 0; b < NUM; b++)
            for (int k = 0; k <= b; k++) step(NUM'(1) << b, 1'b0, b, 1'b1);
        step('0, 1'b1, 0, 1'b1);
        sweep_reads(16);
        // R2 / R9: random independent traffic, then snapshot
        tag = "R2";
        for (int k = 0; k < 200; k++) step(NUM'($urandom), 1'b0, k % 16, 1'b1);
        step('0, 1'b1, 0, 1'b1);
        sweep_reads(16);
        tag = "R9";
        for (int k = 0; k < 20; k++) step(NUM'(1) << 4, 1'b0, k % 16, 1'b1);
        step('0, 1'b1, 0, 1'b1);
        sweep_reads(16);
        // R3: saturation on counter 0 and 8
        tag = "R3";
        for (int k = 0; k < MAXV + 40; k++) step(NUM'(10'h101), 1'b0, k % 16, 1'b1);
        step('0, 1'b1, 0, 1'b1);
        sweep_reads(16);
        // R5: event coincident with strobe goes to the new interval
        tag = "R5";
        for (int k = 0; k < 5; k++) step(NUM'(10'h2AA), 1'b0, k, 1'b1);
        step('1, 1'b1, 1, 1'b1);
        sweep_reads(16);
        step('0, 1'b1, 3, 1'b1);
        sweep_reads(16);
        // R4: back-to-back strobes with events
        tag = "R4";
        for (int k = 0; k < 30; k++) step(NUM'($urandom), k % 3 == 0, k % 16, 1'b1);
        sweep_reads(16);
        // R6: held stable under traffic and reads
        tag = "R6";
        for (int k = 0; k < 100; k++) step(NUM'($urandom), 1'b0, k % 16, 1'b1);
        // R7: full address range incl. out-of-range
        tag = "R7";
        sweep_reads(32);
        // R8: mid-run reset clears live and held
        tag = "R8";
        for (int k = 0; k < 10; k++) step('1, 1'b0, k, 1'b1);
        step('0, 1'b0, 0, 1'b0);
        sweep_reads(16);
        step('0, 1'b1, 0, 1'b1);
        sweep_reads(16);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule